// File: doc/BRIEF.md
# Word-Wide Debug Serial Memory Access Slave

This block is a serial peripheral slave that lets an external debug master read and write a 16-bit wide internal register space one word at a time. The master lowers chip select and sends a command byte and a 16-bit address. After that it moves any number of 16-bit data words, and the address steps by one for each word. Raising chip select ends the transaction at any point.

On a read, the slave first returns a check word. It is made of the command byte followed by the high byte of the address. A master that receives this word knows a live slave answered and can trust the data that follows. While the slave is not selected it does not float its data output. It drives a level that shows whether the attached processor is running.

The serial pins are brought into the system clock domain by a short synchroniser, and edges of the serial clock are found in that domain. The far side is a plain synchronous memory port with separate write and read strobes. Read data is returned one clock after the read strobe.

Top module: `dbgspi_slave`

## Requirements
- R1: A transaction exists only while cs_n is low. Raising cs_n at any bit returns the slave to waiting for a command byte, and the next transaction decodes normally.
- R2: mosi is sampled on rising edges of sclk. miso changes only after falling edges of sclk while the slave is selected.
- R3: The first 8 bits are the command, most significant bit first: 0x02 is write and 0x03 is read. The next 16 bits are the address, also most significant bit first.
- R4: On a write, each complete 16-bit word is written to the current address, and the address then steps by one for the next word.
- R5: On a read, the first 16 bits shifted out on miso, MSB first, are {command byte, address[15:8]}.
- R6: On a read, the words after the check word are the contents of the addressed location and then of consecutive locations, one per 16 clocks.
- R7: While deselected, miso is 0 when cpu_run is 1 and 1 when cpu_run is 0.
- R8: A command byte other than 0x02 or 0x03 causes no write and no read strobe, and miso holds its idle level until cs_n rises. Example: 0x05, or 0xC0, which is 0x03 sent LSB first.
- R9: A data word cut short by cs_n rising is not written.
- R10: The address steps from 0xFFFF to 0x0000 on both reads and writes.
- R11: The read strobe for the first word is issued, with that word's address, as soon as the address is complete and before the check word is shifted out. A write transaction issues no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| cpu_run | input | 1 | High while the attached processor is running |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Write strobe, one clock |
| mem_re | output | 1 | Read strobe, one clock |
| mem_rdata | input | 16 | Read data, valid the clock after mem_re |

## Verification
Write-then-read pairs use data patterns of all zeros, all ones, single high bit and mixed bits at low, middle and high addresses. These separate a correct bit order and address step from swapped or stuck bits, and a wrong check word from wrong data. Longer bursts, bursts across 0xFFFF, a word cut short by chip select, and a header-only write separate correct word counting from off-by-one stepping. Unknown command bytes and a read command sent least significant bit first must leave the memory port silent and miso at its idle level. Both cpu_run levels are tried while deselected.

// File: rtl/dbgspi_pkg.sv
`timescale 1ns/1ps
package dbgspi_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WR,
    PH_RD,
    PH_IGN
  } phase_t;
endpackage

// File: rtl/dbgspi_sync.sv
`timescale 1ns/1ps
module dbgspi_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL[i]}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d_in[i]};
    end
    assign d_out[i] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/dbgspi_ctrl.sv
`timescale 1ns/1ps
module dbgspi_ctrl
  import dbgspi_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              mosi_s,
  input  logic              word_taken,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              rd_vld,
  output logic              load_chk,
  output logic [DATA_W-1:0] chk_word
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int HI_W  = DATA_W - CMD_W;

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, sh_in;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d, re_q, re_d, vld_q, start_q, start_d;

  assign sh_in = {sh_q[DATA_W-2:0], mosi_s};

  always_comb begin
    phase_d = phase_q;  cnt_d = cnt_q;  sh_d = sh_q;  cmd_d = cmd_q;
    ptr_d   = ptr_q;    addr_d = addr_q; wdata_d = wdata_q;
    we_d = 1'b0;  re_d = 1'b0;  start_d = 1'b0;
    if (!cs_act) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
    end else begin
      if (sclk_rise && phase_q != PH_IGN && phase_q != PH_RD) begin
        sh_d  = sh_in;
        cnt_d = cnt_q + 1'b1;
        case (phase_q)
          PH_CMD: if (cnt_q == CNT_W'(CMD_W-1)) begin
            cnt_d = '0;
            cmd_d = sh_in[CMD_W-1:0];
            phase_d = (sh_in[CMD_W-1:0] == OP_WRITE || sh_in[CMD_W-1:0] == OP_READ)
                      ? PH_ADDR : PH_IGN;
          end
          PH_ADDR: if (cnt_q == CNT_W'(ADDR_W-1)) begin
            cnt_d = '0;
            if (cmd_q == OP_READ) begin
              phase_d = PH_RD;
              addr_d  = sh_in[ADDR_W-1:0];
              ptr_d   = sh_in[ADDR_W-1:0] + 1'b1;
              re_d    = 1'b1;
              start_d = 1'b1;
            end else begin
              phase_d = PH_WR;
              ptr_d   = sh_in[ADDR_W-1:0];
            end
          end
          PH_WR: if (cnt_q == CNT_W'(DATA_W-1)) begin
            cnt_d   = '0;
            addr_d  = ptr_q;
            wdata_d = sh_in;
            we_d    = 1'b1;
            ptr_d   = ptr_q + 1'b1;
          end
          default: ;
        endcase
      end
      if (phase_q == PH_RD && word_taken) begin
        addr_d = ptr_q;
        ptr_d  = ptr_q + 1'b1;
        re_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;  cnt_q <= '0;  sh_q <= '0;  cmd_q <= '0;
      ptr_q <= '0;  addr_q <= '0;  wdata_q <= '0;
      we_q <= 1'b0;  re_q <= 1'b0;  vld_q <= 1'b0;  start_q <= 1'b0;
    end else begin
      phase_q <= phase_d;  cnt_q <= cnt_d;  sh_q <= sh_d;  cmd_q <= cmd_d;
      ptr_q <= ptr_d;  addr_q <= addr_d;  wdata_q <= wdata_d;
      we_q <= we_d;  re_q <= re_d;  vld_q <= re_q;  start_q <= start_d;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;
  assign rd_vld    = vld_q;
  assign load_chk  = start_q;
  assign chk_word  = {cmd_q, addr_q[ADDR_W-1 -: HI_W]};

  a_r1_deselect_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> phase_q == PH_CMD);
  a_r8_ignored_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_IGN |-> !we_q && !re_q);
  a_r4_step_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> ptr_q == addr_q + 1'b1);
  a_r11_read_write_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q && re_q));
endmodule

// File: rtl/dbgspi_tx.sv
`timescale 1ns/1ps
module dbgspi_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic              run_s,
  input  logic              load_chk,
  input  logic [DATA_W-1:0] chk_word,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  output logic              miso_q,
  output logic              word_taken
);
  localparam int CNT_W = $clog2(DATA_W);

  logic              xmit_q, xmit_d, miso_d, take_q, take_d;
  logic [DATA_W-1:0] sh_q, sh_d, nxt_q, nxt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    xmit_d = xmit_q;  miso_d = miso_q;  sh_d = sh_q;  nxt_d = nxt_q;
    cnt_d  = cnt_q;   take_d = 1'b0;
    if (rd_vld) nxt_d = rd_data;
    if (!cs_act) begin
      xmit_d = 1'b0;
      cnt_d  = '0;
      miso_d = ~run_s;
    end else if (load_chk) begin
      sh_d   = chk_word;
      xmit_d = 1'b1;
      cnt_d  = '0;
    end else if (xmit_q && sclk_fall) begin
      miso_d = sh_q[DATA_W-1];
      sh_d   = {sh_q[DATA_W-2:0], 1'b0};
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(DATA_W-1)) begin
        sh_d   = nxt_q;
        take_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xmit_q <= 1'b0;  miso_q <= 1'b0;  sh_q <= '0;  nxt_q <= '0;
      cnt_q  <= '0;    take_q <= 1'b0;
    end else begin
      xmit_q <= xmit_d;  miso_q <= miso_d;  sh_q <= sh_d;  nxt_q <= nxt_d;
      cnt_q  <= cnt_d;   take_q <= take_d;
    end
  end

  assign word_taken = take_q;

  a_r2_change_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$stable(miso_q)) |-> $past(sclk_fall));
endmodule

// File: rtl/dbgspi_slave.sv
`timescale 1ns/1ps
module dbgspi_slave #(
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              cpu_run,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic [3:0] raw, synced;
  logic       cs_s, sclk_s, mosi_s, run_s, sclk_prev_q;
  assign raw = {cpu_run, mosi, sclk, cs_n};

  dbgspi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_in(raw), .d_out(synced));

  assign {run_s, mosi_s, sclk_s, cs_s} = synced;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sclk_prev_q <= 1'b0;
    else         sclk_prev_q <= sclk_s;
  end

  logic cs_act, sclk_rise, sclk_fall, word_taken, rd_vld, load_chk, miso_q;
  logic [DATA_W-1:0] chk_word;
  assign cs_act    = ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;

  dbgspi_ctrl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .mosi_s(mosi_s), .word_taken(word_taken), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .rd_vld(rd_vld),
    .load_chk(load_chk), .chk_word(chk_word));

  dbgspi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_sn), .cs_act(cs_act), .sclk_fall(sclk_fall),
    .run_s(run_s), .load_chk(load_chk), .chk_word(chk_word), .rd_vld(rd_vld),
    .rd_data(mem_rdata), .miso_q(miso_q), .word_taken(word_taken));

  assign miso = cs_act ? miso_q : ~run_s;

  a_r7_select_keeps_level: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(cs_act) |-> miso == $past(miso));
endmodule

// File: tb/dbgspi_slave_test.sv
`timescale 1ns/1ps
module dbgspi_slave_test;
  localparam int HALF = 32;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi, cpu_run, miso, mem_we, mem_re;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  dbgspi_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .cpu_run(cpu_run), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata));

  logic [15:0] mem [0:255];
  int wr_cnt = 0, rd_cnt = 0;
  logic [15:0] first_rd_addr;
  logic first_seen;
  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr[7:0]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr[7:0]];
      rd_cnt <= rd_cnt + 1;
      if (!first_seen) begin first_rd_addr <= mem_addr; first_seen <= 1'b1; end
    end
  end

  function automatic logic [15:0] seed(input int i);
    return 16'(i * 40503 + 7);
  endfunction

  int total = 0, bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] wbuf [0:7];
  logic [15:0] rbuf [0:8];
  logic        hdr_level_ok;

  task automatic xfer(input logic b, output logic r);
    mosi = b;
    #(HALF);
    r = miso;
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
  endtask

  task automatic spi_txn(input logic [7:0] cmd, input logic [15:0] addr,
                         input int nw, input int extra, input logic idle_lvl);
    logic r;
    int nword;
    nword = (cmd == 8'h03) ? nw + 1 : nw;
    hdr_level_ok = 1'b1;
    first_seen = 1'b0;
    cs_n = 1'b0;
    #(HALF * 2);
    for (int b = 7; b >= 0; b--) begin
      xfer(cmd[b], r);
      if (r !== idle_lvl) hdr_level_ok = 1'b0;
    end
    for (int b = 15; b >= 0; b--) begin
      xfer(addr[b], r);
      if (r !== idle_lvl) hdr_level_ok = 1'b0;
    end
    for (int w = 0; w < nword; w++)
      for (int b = 15; b >= 0; b--) begin
        xfer(wbuf[w][b], r);
        rbuf[w][b] = r;
        if (cmd != 8'h03 && r !== idle_lvl) hdr_level_ok = 1'b0;
      end
    for (int k = 0; k < extra; k++) begin
      xfer(1'b1, r);
      if (cmd != 8'h03 && r !== idle_lvl) hdr_level_ok = 1'b0;
    end
    #(HALF);
    cs_n = 1'b1;
    #(HALF * 4);
  endtask

  localparam logic [31:0] VEC [0:4] = '{
    {16'h0010, 16'h1234}, {16'h7F3E, 16'hA5C3}, {16'h1200, 16'h0000},
    {16'h0041, 16'hFFFF}, {16'h8000, 16'h8001}};

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < 256; i++) mem[i] = seed(i);
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; cpu_run = 1'b1;
    first_seen = 1'b0;
    #100;
    rst_n = 1'b1;
    #40;
    chk("R7 reset idle run=1", {31'd0, miso}, 32'd0);
    chk("R11 reset no strobes", {30'd0, mem_we, mem_re}, 32'd0);
    cpu_run = 1'b0;
    #40;
    chk("R7 idle run=0", {31'd0, miso}, 32'd1);
    cpu_run = 1'b1;
    #40;
    chk("R7 idle run=1 again", {31'd0, miso}, 32'd0);

    for (int v = 0; v < 5; v++) begin
      logic [15:0] a, d;
      a = VEC[v][31:16];
      d = VEC[v][15:0];
      wbuf[0] = d; wbuf[1] = ~d;
      r0 = rd_cnt;
      spi_txn(8'h02, a, 2, 0, 1'b0);
      chk("R4 first word", {16'd0, mem[a[7:0]]}, {16'd0, d});
      chk("R4 next word", {16'd0, mem[8'(a[7:0] + 1)]}, {16'd0, ~d});
      chk("R11 write has no read", rd_cnt - r0, 0);
      wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
      spi_txn(8'h03, a, 2, 0, 1'b0);
      chk("R5 check word", {16'd0, rbuf[0]}, {16'd0, 8'h03, a[15:8]});
      chk("R3 read data", {16'd0, rbuf[1]}, {16'd0, d});
      chk("R6 read next", {16'd0, rbuf[2]}, {16'd0, ~d});
      chk("R11 first strobe address", {16'd0, first_rd_addr}, {16'd0, a});
    end

    // R6: longer read burst from untouched seeded locations
    for (int k = 0; k < 4; k++) wbuf[k] = 16'h0;
    spi_txn(8'h03, 16'h3350, 3, 0, 1'b0);
    chk("R5 check word burst", {16'd0, rbuf[0]}, {16'd0, 16'h0333});
    for (int k = 0; k < 3; k++)
      chk("R6 burst word", {16'd0, rbuf[k+1]}, {16'd0, seed(8'h50 + k)});

    // R8: unknown command and a read command sent LSB first
    w0 = wr_cnt; r0 = rd_cnt;
    wbuf[0] = 16'hDEAD; wbuf[1] = 16'hBEEF;
    spi_txn(8'h05, 16'h0060, 2, 0, 1'b0);
    chk("R8 unknown no strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
    chk("R8 unknown miso idle", {31'd0, hdr_level_ok}, 32'd1);
    chk("R8 mem untouched", {16'd0, mem[8'h60]}, {16'd0, seed(8'h60)});
    cpu_run = 1'b0;
    #(HALF * 2);
    spi_txn(8'hC0, 16'h0060, 2, 0, 1'b1);
    chk("R3 LSB-first read rejected", (wr_cnt - w0) + (rd_cnt - r0), 0);
    chk("R8 miso idle high", {31'd0, hdr_level_ok}, 32'd1);
    cpu_run = 1'b1;
    #(HALF * 2);

    // R9: partial word dropped
    w0 = wr_cnt;
    wbuf[0] = 16'h4C4C;
    spi_txn(8'h02, 16'h0020, 1, 9, 1'b0);
    chk("R9 full word written", {16'd0, mem[8'h20]}, {16'd0, 16'h4C4C});
    chk("R9 partial word dropped", {16'd0, mem[8'h21]}, {16'd0, seed(8'h21)});
    chk("R9 one write only", wr_cnt - w0, 1);

    // R1: header-only write, then a normal read
    w0 = wr_cnt;
    spi_txn(8'h02, 16'h0030, 0, 0, 1'b0);
    chk("R1 header only no write", wr_cnt - w0, 0);
    wbuf[0] = 0; wbuf[1] = 0;
    spi_txn(8'h03, 16'h0020, 1, 0, 1'b0);
    chk("R1 restart check word", {16'd0, rbuf[0]}, {16'd0, 16'h0300});
    chk("R1 restart data", {16'd0, rbuf[1]}, {16'd0, 16'h4C4C});

    // R10: wrap at the top of the address space
    wbuf[0] = 16'h1111; wbuf[1] = 16'h2222;
    spi_txn(8'h02, 16'hFFFF, 2, 0, 1'b0);
    chk("R10 write top", {16'd0, mem[8'hFF]}, {16'd0, 16'h1111});
    chk("R10 write wrapped", {16'd0, mem[8'h00]}, {16'd0, 16'h2222});
    wbuf[0] = 0; wbuf[1] = 0; wbuf[2] = 0;
    spi_txn(8'h03, 16'hFFFF, 2, 0, 1'b0);
    chk("R5 check word top", {16'd0, rbuf[0]}, {16'd0, 16'h03FF});
    chk("R10 read top", {16'd0, rbuf[1]}, {16'd0, 16'h1111});
    chk("R10 read wrapped", {16'd0, rbuf[2]}, {16'd0, 16'h2222});

    // R2/R7: output returns to idle level after a read
    chk("R7 idle after read", {31'd0, miso}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule